// File: doc/BRIEF.md
# Four-Level Priority Interrupt Controller

This block decides which of six interrupt sources a processor core should service next. The sources are two external request pins (active low), two timer overflows, a serial port (its receive and transmit events share one request) and a comparator. Software configures the block through a small register-write port. It can set a per-source enable, a global enable, two priority bits per source that together give four levels, and an edge or level mode for each external pin. The latched request flags can also be written through this port.

The block only arbitrates on cycles where the core signals that an instruction has finished. On those cycles it picks the eligible request with the highest level. Requests at the same level are resolved by fixed vector order. The chosen request is launched only if its level is strictly higher than every level already in service. When a request is launched, the block drives a one-cycle valid pulse with the vector address and level, and marks that level busy in a per-level active mask. Where hardware clearing is allowed, it also clears the request flag. A return-from-interrupt strobe retires the highest busy level.

Top module: `irq_prio_ctrl`

## Requirements
- R1: The vector addresses by source are: external 0 = 0x0003, timer 0 = 0x000B, external 1 = 0x0013, timer 1 = 0x001B, serial = 0x0023, comparator = 0x0033. This list is also the source index order 0 to 5.
- R2: The enable register (wr_sel 0) holds per-source enable bits 0 to 5 in source index order and the global enable in bit 7. A source is never launched while its own bit or the global bit is 0.
- R3: A source's level is {high bit, low bit}. The high bits come from wr_sel 2 and the low bits from wr_sel 1, both in source index order. The eligible request with the highest level is chosen.
- R4: Among eligible requests at the same level, the one with the lower vector address wins.
- R5: A request is launched only if its level is strictly above the highest level set in active_levels. A level-3 service is therefore never preempted.
- R6: active_levels has one bit per level. A launch sets the bit of its level. reti clears the highest set bit and launches nothing in that cycle. reti with an empty mask changes nothing.
- R7: Arbitration happens only in cycles with insn_end high. vec_valid, vec_addr and vec_level are registered, so they appear one cycle after that insn_end cycle. vec_valid is 0 in every other cycle.
- R8: In edge mode (mode register wr_sel 4: bit 0 for external 0, bit 1 for external 1, 1 = edge), an external flag is set when the pin goes from 1 to 0 between two sampled cycles. The flag is cleared when that source is launched.
- R9: In level mode, an external flag equals the inverted pin from the previous cycle. It is not cleared by a launch, and software writes to it are ignored.
- R10: Timer flags are cleared on launch. The serial flags (bit 4 receive, bit 5 transmit) and the comparator flag (bit 6) are never cleared by a launch.
- R11: The flag register (wr_sel 3) has bit 0 = ext0, bit 1 = timer0, bit 2 = ext1, bit 3 = timer1, bit 4 = receive, bit 5 = transmit, bit 6 = comparator. Software writes act like hardware events. In one cycle, a software write takes precedence over a hardware set, and a hardware set takes precedence over a launch clear.
- R12: After reset, all configuration registers, flags, active_levels and vec_valid are 0, and the previous pin samples are taken as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin_n | input | 2 | External request pins, active low |
| timer_ovf | input | 2 | Timer overflow pulses |
| uart_rx_done | input | 1 | Serial receive event pulse |
| uart_tx_done | input | 1 | Serial transmit event pulse |
| cmp_evt | input | 1 | Comparator event pulse |
| insn_end | input | 1 | Instruction boundary strobe |
| reti | input | 1 | Return-from-interrupt strobe |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0 enable, 1 prio low, 2 prio high, 3 flags, 4 mode |
| wr_data | input | 8 | Register write data |
| vec_valid | output | 1 | One-cycle launch pulse |
| vec_addr | output | 16 | Vector address of the launched source |
| vec_level | output | 2 | Level of the launched source |
| active_levels | output | 4 | Busy mask, one bit per level |
| flag_q | output | 7 | Latched request flags |

## Verification
The assertions assume that insn_end and reti are plain single-cycle strobes. They also assume that the external pins are already synchronous to clk, so a level-mode flag can be checked against the previous cycle's pin value. The stimulus drives every input only at the falling clock edge. Pins toggle rarely and pulses are sparse. reti is issued with an empty busy mask only occasionally, which exercises the no-effect case without leaving the nesting state undefined.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    localparam int NSRC   = 6;
    localparam int SRC_W  = $clog2(NSRC);
    localparam int NLVL   = 4;
    localparam int LVL_W  = $clog2(NLVL);
    localparam int NFLAG  = 7;
    localparam int NEXT   = 2;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 16;
    localparam int GEN_BIT = DATA_W - 1;

    typedef enum logic [2:0] {
        SEL_EN   = 3'd0,
        SEL_PLO  = 3'd1,
        SEL_PHI  = 3'd2,
        SEL_FLAG = 3'd3,
        SEL_MODE = 3'd4
    } wsel_e;

    typedef struct packed {
        logic             hit;
        logic [SRC_W-1:0] src;
        logic [LVL_W-1:0] lvl;
    } pick_t;

    typedef struct packed {
        logic             any;
        logic [LVL_W-1:0] lvl;
    } top_t;

    function automatic logic [ADDR_W-1:0] vec_of(logic [SRC_W-1:0] s);
        logic [ADDR_W-1:0] a;
        if (s == SRC_W'(NSRC - 1))
            a = ADDR_W'(16'h0033);
        else
            a = ADDR_W'({s, 3'b011});
        return a;
    endfunction

    function automatic top_t top_of(logic [NLVL-1:0] st);
        top_t t;
        t = '0;
        for (int i = 0; i < NLVL; i++) begin
            if (st[i]) begin
                t.any = 1'b1;
                t.lvl = LVL_W'(i);
            end
        end
        return t;
    endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_prio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [NSRC-1:0]   src_en,
    output logic              glob_en,
    output logic [NSRC-1:0]   prio_lo,
    output logic [NSRC-1:0]   prio_hi,
    output logic [NEXT-1:0]   edge_mode
);

    always_ff @(posedge clk) begin
        if (rst) begin
            src_en    <= '0;
            glob_en   <= 1'b0;
            prio_lo   <= '0;
            prio_hi   <= '0;
            edge_mode <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_EN: begin
                    src_en  <= wr_data[NSRC-1:0];
                    glob_en <= wr_data[GEN_BIT];
                end
                SEL_PLO:  prio_lo   <= wr_data[NSRC-1:0];
                SEL_PHI:  prio_hi   <= wr_data[NSRC-1:0];
                SEL_MODE: edge_mode <= wr_data[NEXT-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_prio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NEXT-1:0]   ext_pin_n,
    input  logic [NEXT-1:0]   timer_ovf,
    input  logic              rx_evt,
    input  logic              tx_evt,
    input  logic              cmp_evt,
    input  logic [NEXT-1:0]   edge_mode,
    input  logic              sw_wr,
    input  logic [NFLAG-1:0]  sw_data,
    input  logic              clr_en,
    input  logic [SRC_W-1:0]  clr_src,
    output logic [NFLAG-1:0]  flags,
    output logic [NSRC-1:0]   req
);

    logic [NEXT-1:0]  pin_prev;
    logic [NSRC-1:0]  src_hit;
    logic [NFLAG-1:0] hw_set;
    logic [NFLAG-1:0] hw_clr;
    logic [NFLAG-1:0] follow;
    logic [NFLAG-1:0] follow_val;
    logic [NFLAG-1:0] flags_nxt;

    always_comb begin
        src_hit = '0;
        if (clr_en) src_hit[clr_src] = 1'b1;
    end

    // external pins sit on even flag bits, timers on odd bits below 4
    for (genvar j = 0; j < NEXT; j++) begin : g_ext
        localparam int EB = 2 * j;
        localparam int TB = 2 * j + 1;
        assign hw_set[EB]     = edge_mode[j] & pin_prev[j] & ~ext_pin_n[j];
        assign hw_clr[EB]     = src_hit[EB] & edge_mode[j];
        assign follow[EB]     = ~edge_mode[j];
        assign follow_val[EB] = ~ext_pin_n[j];
        assign hw_set[TB]     = timer_ovf[j];
        assign hw_clr[TB]     = src_hit[TB];
        assign follow[TB]     = 1'b0;
        assign follow_val[TB] = 1'b0;
    end

    assign hw_set[4]     = rx_evt;
    assign hw_set[5]     = tx_evt;
    assign hw_set[6]     = cmp_evt;
    assign hw_clr[6:4]   = '0;
    assign follow[6:4]   = '0;
    assign follow_val[6:4] = '0;

    always_comb begin
        for (int b = 0; b < NFLAG; b++) begin
            if (follow[b])
                flags_nxt[b] = follow_val[b];
            else if (sw_wr)
                flags_nxt[b] = sw_data[b];
            else if (hw_set[b])
                flags_nxt[b] = 1'b1;
            else if (hw_clr[b])
                flags_nxt[b] = 1'b0;
            else
                flags_nxt[b] = flags[b];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags    <= '0;
            pin_prev <= '1;
        end else begin
            flags    <= flags_nxt;
            pin_prev <= ext_pin_n;
        end
    end

    assign req = {flags[6], flags[5] | flags[4], flags[3:0]};

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_prio_pkg::*;
(
    input  logic [NSRC-1:0] req,
    input  logic [NSRC-1:0] src_en,
    input  logic            glob_en,
    input  logic [NSRC-1:0] prio_lo,
    input  logic [NSRC-1:0] prio_hi,
    input  logic [NLVL-1:0] busy,
    output pick_t           pick,
    output logic            launch_ok
);

    logic [NSRC-1:0]  elig;
    logic [LVL_W-1:0] lvl_of [NSRC];
    top_t             top;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign elig[i]   = req[i] & src_en[i] & glob_en;
        assign lvl_of[i] = {prio_hi[i], prio_lo[i]};
    end

    always_comb begin
        pick = '0;
        for (int l = NLVL - 1; l >= 0; l--) begin
            for (int i = 0; i < NSRC; i++) begin
                if (!pick.hit && elig[i] && lvl_of[i] == LVL_W'(l)) begin
                    pick.hit = 1'b1;
                    pick.src = SRC_W'(i);
                    pick.lvl = LVL_W'(l);
                end
            end
        end
    end

    assign top       = top_of(busy);
    assign launch_ok = pick.hit && (!top.any || pick.lvl > top.lvl);

endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack
    import irq_prio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [LVL_W-1:0] push_lvl,
    input  logic             pop,
    output logic [NLVL-1:0]  busy
);

    top_t            top;
    logic [NLVL-1:0] busy_nxt;

    assign top = top_of(busy);

    always_comb begin
        busy_nxt = busy;
        if (pop) begin
            if (top.any) busy_nxt[top.lvl] = 1'b0;
        end else if (push) begin
            busy_nxt[push_lvl] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) busy <= '0;
        else     busy <= busy_nxt;
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        ext_pin_n,
    input  logic [1:0]        timer_ovf,
    input  logic              uart_rx_done,
    input  logic              uart_tx_done,
    input  logic              cmp_evt,
    input  logic              insn_end,
    input  logic              reti,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [7:0]        wr_data,
    output logic              vec_valid,
    output logic [15:0]       vec_addr,
    output logic [1:0]        vec_level,
    output logic [3:0]        active_levels,
    output logic [6:0]        flag_q
);

    logic [NSRC-1:0] src_en, prio_lo, prio_hi, req;
    logic            glob_en;
    logic [NEXT-1:0] edge_mode;
    logic [NLVL-1:0] busy;
    pick_t           pick;
    logic            launch_ok, launch, sw_flag_wr;

    assign launch     = insn_end && !reti && launch_ok;
    assign sw_flag_wr = wr_en && (wr_sel == SEL_FLAG);

    irq_cfg_regs u_cfg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .src_en(src_en), .glob_en(glob_en), .prio_lo(prio_lo), .prio_hi(prio_hi),
        .edge_mode(edge_mode)
    );

    irq_flag_bank u_flags (
        .clk(clk), .rst(rst), .ext_pin_n(ext_pin_n), .timer_ovf(timer_ovf),
        .rx_evt(uart_rx_done), .tx_evt(uart_tx_done), .cmp_evt(cmp_evt),
        .edge_mode(edge_mode), .sw_wr(sw_flag_wr), .sw_data(wr_data[NFLAG-1:0]),
        .clr_en(launch), .clr_src(pick.src), .flags(flag_q), .req(req)
    );

    irq_arbiter u_arb (
        .req(req), .src_en(src_en), .glob_en(glob_en), .prio_lo(prio_lo),
        .prio_hi(prio_hi), .busy(busy), .pick(pick), .launch_ok(launch_ok)
    );

    irq_level_stack u_stack (
        .clk(clk), .rst(rst), .push(launch), .push_lvl(pick.lvl), .pop(reti),
        .busy(busy)
    );

    assign active_levels = busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_valid <= 1'b0;
            vec_addr  <= '0;
            vec_level <= '0;
        end else begin
            vec_valid <= launch;
            if (launch) begin
                vec_addr  <= vec_of(pick.src);
                vec_level <= pick.lvl;
            end
        end
    end

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
    import irq_prio_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             insn_end,
    input logic             reti,
    input logic             vec_valid,
    input logic [LVL_W-1:0] vec_level,
    input logic [NLVL-1:0]  active_levels,
    input logic [6:0]       flag_q,
    input logic [1:0]       ext_pin_n,
    input logic             glob_en,
    input logic [NEXT-1:0]  edge_mode
);

    logic [NLVL-1:0] prev_act;
    top_t            prev_top;

    always_ff @(posedge clk) begin
        if (rst) prev_act <= '0;
        else     prev_act <= active_levels;
    end
    assign prev_top = top_of(prev_act);

    // R7
    launch_on_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> ($past(insn_end) && !$past(reti)));

    // R6
    level_marked_chk: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> active_levels[vec_level]);

    // R5
    strict_preempt_chk: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> (!prev_top.any || vec_level > prev_top.lvl));

    // R2
    global_mask_chk: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> $past(glob_en));

    // R6
    pop_one_chk: assert property (@(posedge clk) disable iff (rst)
        (reti && active_levels != '0) |=>
            ($countones(active_levels) == $countones($past(active_levels)) - 1));

    // R9
    level_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !edge_mode[0] |=> (flag_q[0] == !$past(ext_pin_n[0])));

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .insn_end(insn_end), .reti(reti),
    .vec_valid(vec_valid), .vec_level(vec_level), .active_levels(active_levels),
    .flag_q(flag_q), .ext_pin_n(ext_pin_n), .glob_en(glob_en),
    .edge_mode(edge_mode)
);

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  ext_pin_n = 2'b11;
    logic [1:0]  timer_ovf = '0;
    logic        uart_rx_done = 0, uart_tx_done = 0, cmp_evt = 0;
    logic        insn_end = 0, reti = 0, wr_en = 0;
    logic [2:0]  wr_sel = '0;
    logic [7:0]  wr_data = '0;
    logic        vec_valid;
    logic [15:0] vec_addr;
    logic [1:0]  vec_level;
    logic [3:0]  active_levels;
    logic [6:0]  flag_q;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model state
    logic [7:0]  m_en;
    logic [5:0]  m_plo, m_phi;
    logic [1:0]  m_mode, m_prev;
    logic [6:0]  m_fl;
    logic [3:0]  m_act;
    logic        m_vv;
    logic [15:0] m_addr;
    logic [1:0]  m_lvl;

    irq_prio_ctrl uut (.*);

    always #2.5 clk = ~clk;

    function automatic logic [15:0] ref_vec(int s);
        case (s)
            0: return 16'h0003;
            1: return 16'h000B;
            2: return 16'h0013;
            3: return 16'h001B;
            4: return 16'h0023;
            default: return 16'h0033;
        endcase
    endfunction

    function automatic int ref_top(logic [3:0] a);
        int t = -1;
        for (int i = 0; i < 4; i++) if (a[i]) t = i;
        return t;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_en = '0; m_plo = '0; m_phi = '0; m_mode = '0; m_prev = 2'b11;
        m_fl = '0; m_act = '0; m_vv = 0; m_addr = '0; m_lvl = '0;
    endtask

    // compute the next state from current inputs, then clock and compare
    task automatic step();
        logic [5:0] rq;
        int best, blvl, top;
        logic grant;
        logic [6:0] nf;
        logic [6:0] hs, hc;
        rq = {m_fl[6], m_fl[5] | m_fl[4], m_fl[3:0]};
        best = -1; blvl = -1;
        for (int l = 3; l >= 0; l--)
            for (int i = 0; i < 6; i++)
                if (best < 0 && m_en[7] && m_en[i] && rq[i] && int'({m_phi[i], m_plo[i]}) == l) begin
                    best = i; blvl = l;
                end
        top = ref_top(m_act);
        grant = insn_end && !reti && best >= 0 && blvl > top;
        hs = {cmp_evt, uart_tx_done, uart_rx_done, timer_ovf[1],
              m_mode[1] & m_prev[1] & ~ext_pin_n[1], timer_ovf[0],
              m_mode[0] & m_prev[0] & ~ext_pin_n[0]};
        hc = '0;
        if (grant) begin
            if (best == 0 && m_mode[0]) hc[0] = 1;
            if (best == 1) hc[1] = 1;
            if (best == 2 && m_mode[1]) hc[2] = 1;
            if (best == 3) hc[3] = 1;
        end
        for (int b = 0; b < 7; b++) begin
            nf[b] = m_fl[b];
            if (hc[b]) nf[b] = 0;
            if (hs[b]) nf[b] = 1;
            if (wr_en && wr_sel == 3) nf[b] = wr_data[b];
        end
        if (!m_mode[0]) nf[0] = ~ext_pin_n[0];
        if (!m_mode[1]) nf[2] = ~ext_pin_n[1];
        m_prev = ext_pin_n;
        if (wr_en) case (wr_sel)
            0: m_en = wr_data & 8'hBF;
            1: m_plo = wr_data[5:0];
            2: m_phi = wr_data[5:0];
            4: m_mode = wr_data[1:0];
            default: ;
        endcase
        if (reti) begin
            if (top >= 0) m_act[top] = 0;
        end else if (grant) m_act[blvl] = 1;
        m_fl = nf;
        m_vv = grant;
        if (grant) begin
            m_addr = ref_vec(best); m_lvl = 2'(blvl);
        end
        @(posedge clk);
        @(negedge clk);
        chk("R7 vec_valid", vec_valid, m_vv);
        if (m_vv) begin
            chk("R1 vec_addr", vec_addr, m_addr);
            chk("R3 vec_level", vec_level, m_lvl);
        end
        chk("R6 active_levels", active_levels, m_act);
        chk("R11 flags", flag_q, m_fl);
        timer_ovf = '0; uart_rx_done = 0; uart_tx_done = 0; cmp_evt = 0;
        insn_end = 0; reti = 0; wr_en = 0;
    endtask

    task automatic wr(logic [2:0] s, logic [7:0] d);
        wr_en = 1; wr_sel = s; wr_data = d;
        step();
    endtask

    task automatic boundary();
        insn_end = 1;
        step();
    endtask

    task automatic do_reti();
        reti = 1;
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R12 reset state
        chk("R12 vec_valid", vec_valid, 0);
        chk("R12 active", active_levels, 0);
        chk("R12 flags", flag_q, 0);

        wr(4, 8'h03);                 // both externals edge mode
        // R2 global enable off masks a pending timer
        wr(0, 8'h3F);
        timer_ovf = 2'b01; step();
        boundary();
        chk("R2 masked", vec_valid, 0);
        chk("R2 flag kept", flag_q[1], 1);
        wr(0, 8'hBF);
        boundary();
        chk("R1 timer0 vector", vec_addr, 16'h000B);
        chk("R10 timer0 cleared", flag_q[1], 0);
        do_reti();
        chk("R6 popped", active_levels, 0);

        // R4 tie: serial + comparator, both level 0
        wr(3, 8'h50);
        boundary();
        chk("R4 tie serial first", vec_addr, 16'h0023);
        chk("R10 serial kept", flag_q, 7'h50);
        do_reti();
        // R3 comparator raised to level 2
        wr(2, 8'h20);
        boundary();
        chk("R3 higher level wins", vec_addr, 16'h0033);
        chk("R3 level", vec_level, 2);
        boundary();
        chk("R5 no preempt by lower", vec_valid, 0);
        // R8 edge fall on ext0 with level 3 preempts
        wr(1, 8'h01); wr(2, 8'h21);
        ext_pin_n = 2'b10; step();
        chk("R8 edge flag set", flag_q[0], 1);
        boundary();
        chk("R5 preempt by level3", vec_addr, 16'h0003);
        chk("R8 edge cleared", flag_q[0], 0);
        chk("R6 two levels", active_levels, 4'b1100);
        timer_ovf = 2'b10; wr(1, 8'h09); wr(2, 8'h29);
        boundary();
        chk("R5 level3 not preempted", vec_valid, 0);
        // R6 reti plus boundary same cycle: no launch
        reti = 1; insn_end = 1; step();
        chk("R6 reti blocks launch", vec_valid, 0);
        do_reti(); do_reti(); do_reti();
        chk("R6 empty reti", active_levels, 0);
        // R9 level mode follows pin, ignores sw write, not cleared
        wr(4, 8'h00);
        ext_pin_n = 2'b10; step();
        chk("R9 level follows", flag_q[0], 1);
        wr(3, 8'h00);
        chk("R9 sw ignored", flag_q[0], 1);
        wr(3, 8'h0A);  // timers via sw
        wr(3, 8'h00);
        chk("R11 sw clears", flag_q[3:1], 3'b000);
        ext_pin_n = 2'b11; step();

        // random phase
        for (int n = 0; n < 4000; n++) begin
            for (int j = 0; j < 2; j++)
                if ($urandom_range(7) == 0) ext_pin_n[j] = ~ext_pin_n[j];
            timer_ovf[0] = ($urandom_range(15) == 0);
            timer_ovf[1] = ($urandom_range(15) == 0);
            uart_rx_done = ($urandom_range(31) == 0);
            uart_tx_done = ($urandom_range(31) == 0);
            cmp_evt      = ($urandom_range(31) == 0);
            insn_end     = ($urandom_range(1) == 0);
            reti         = ($urandom_range(7) == 0);
            if ($urandom_range(11) == 0) begin
                wr_en = 1;
                wr_sel = 3'($urandom_range(5));
                wr_data = 8'($urandom);
                if (wr_sel == 0 && $urandom_range(3) != 0) wr_data[7] = 1;
            end
            step();
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule